// File: doc/BRIEF.md
# Toggle-chain counter with lowest-set-bit row select

This block is a fully synchronous binary up-counter whose stages are toggle flip-flops driven by an AND chain. Besides the count it presents a one-hot vector with one line per bit position. The single active line marks the lowest bit of the count that is 1. The line can drive the row enable of a small register file directly, with no address decoder and no priority encoder in between.

A finish flag comes from the top of the same chain: it is high while every ordinary count bit is 1, which is the last step before the terminal count. The counter has W ordinary stages plus one terminal stage. On the step after the finish flag, the terminal stage sets, the count reads 2^W, and the extra select line W goes high. From then on the counter holds until reset. A typical use is to step through the 2^W − 1 moves of an iterative stack-shuffling algorithm, one row per disk, and stop when the terminal line rises.

Top module: `lsb_select_counter`

## Requirements
- R1: While rst_ni is low at a rising clock edge, the next state has count_o = 0, sel_o = 0 and finish_o = 0. The reset is synchronous, so nothing changes between edges.
- R2: At each rising edge with rst_ni high, adv_i high and count_o below 2^W, count_o increases by exactly 1. Starting from reset, the first advance gives 1.
- R3: At each rising edge with rst_ni high and adv_i low, count_o keeps its value.
- R4: Bit k of the count changes only on an advancing edge where all bits below k are 1. Bits above the lowest 0 bit therefore never move on that edge.
- R5: sel_o has W+1 lines. Line k is high exactly when count bit k is 1 and every lower count bit is 0. At most one line is high.
- R6: When count_o is 0, every line of sel_o is low.
- R7: finish_o is high exactly when count_o equals 2^W − 1.
- R8: Once count_o reaches 2^W, sel_o line W is high. count_o then holds at 2^W whatever adv_i does, until reset.
- R9: If rst_ni is low and adv_i is high at the same edge, the reset wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| adv_i | input | 1 | Advance enable; the count steps by one when high |
| count_o | output | W+1 | Count value; bit W is the terminal stage |
| sel_o | output | W+1 | One-hot select of the lowest set count bit |
| finish_o | output | 1 | High when all ordinary count bits are 1 |

## Verification
Two pairs of functions can fall in the same cycle. The first is a reset arriving with the advance enable high, which the bench provokes in the middle of a run and again at the terminal count; it is judged by the count reading 0, not 1, after that edge. The second is the advance that lands on the all-ones count. On that edge the finish flag falls, the terminal select line rises and the ordinary bits wrap together; the bench holds advance high past this point and expects the count to stay at 2^W. Every cycle is compared against a behavioural integer model.

// File: rtl/lsb_select_counter_pkg.sv
package lsb_select_counter_pkg;
  localparam int unsigned DEF_WIDTH = 8;
endpackage

// File: rtl/lsb_toggle_stage.sv
module lsb_toggle_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (tgl_i) q_o <= ~q_o;
  end
endmodule

// File: rtl/lsb_carry_chain.sv
module lsb_carry_chain #(
  parameter int unsigned W = 8
) (
  input  logic [W:0] q_i,
  input  logic       adv_i,
  output logic [W:0] tgl_o,
  output logic [W:0] sel_o,
  output logic       fin_o
);
  logic [W:0] ones;   // all lower bits 1
  logic [W:0] zeros;  // all lower bits 0
  logic       adv_eff;

  // terminal stage freezes the count
  assign adv_eff  = adv_i & ~q_i[W];
  assign ones[0]  = 1'b1;
  assign zeros[0] = 1'b1;

  for (genvar k = 1; k <= W; k++) begin : g_chain
    assign ones[k]  = ones[k-1]  &  q_i[k-1];
    assign zeros[k] = zeros[k-1] & ~q_i[k-1];
  end

  for (genvar k = 0; k <= W; k++) begin : g_out
    assign tgl_o[k] = adv_eff & ones[k];
    assign sel_o[k] = q_i[k] & zeros[k];
  end

  assign fin_o = ones[W] & ~q_i[W];
endmodule

// File: rtl/lsb_select_counter.sv
module lsb_select_counter
  import lsb_select_counter_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W:0]   count_o,
  output logic [W:0]   sel_o,
  output logic         finish_o
);
  localparam int unsigned NSTG = W + 1;

  logic [NSTG-1:0] q;
  logic [NSTG-1:0] tgl;

  for (genvar k = 0; k < NSTG; k++) begin : g_stage
    lsb_toggle_stage u_stg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tgl_i  (tgl[k]),
      .q_o    (q[k])
    );
  end

  lsb_carry_chain #(.W(W)) u_chain (
    .q_i   (q),
    .adv_i (adv_i),
    .tgl_o (tgl),
    .sel_o (sel_o),
    .fin_o (finish_o)
  );

  assign count_o = q;
endmodule

// File: rtl/lsb_select_counter_chk.sv
module lsb_select_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       adv_i,
  input logic [W:0] count_o,
  input logic [W:0] sel_o,
  input logic       finish_o
);
  localparam logic [W:0] TERM = {1'b1, {W{1'b0}}};
  localparam logic [W:0] FULL = {1'b0, {W{1'b1}}};

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (count_o == '0 && sel_o == '0 && !finish_o));

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && count_o != TERM) |=> count_o == $past(count_o) + 1'b1);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(count_o));

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o) && ((sel_o & count_o) == sel_o));

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == '0 |-> sel_o == '0);

  p_finish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> count_o == FULL);

  p_terminal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[W] |=> (count_o == TERM));
endmodule

bind lsb_select_counter lsb_select_counter_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .adv_i    (adv_i),
  .count_o  (count_o),
  .sel_o    (sel_o),
  .finish_o (finish_o)
);

// File: tb/sim_lsb_select_counter.sv
module sim_lsb_select_counter;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int TERM = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adv = 1'b0;
  logic [W:0]   count;
  logic [W:0]   sel;
  logic         fin;

  int n_chk = 0;
  int n_fail = 0;
  int model = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsb_select_counter #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv),
    .count_o(count), .sel_o(sel), .finish_o(fin)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (!rst_n)                   model <= 0;
    else if (adv && model < TERM) model <= model + 1;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int es;
    es = (model == 0) ? 0 : (model & -model);
    chk(model == 0 ? "R1/R6 count" : "R2/R3/R4/R8 count", int'(count), model);
    chk(model == 0 ? "R6 sel" : (model == TERM ? "R8 sel" : "R5 sel"), int'(sel), es);
    chk("R7 finish", int'(fin), (model == TERM - 1) ? 1 : 0);
  endtask

  task automatic cyc(bit r, bit a);
    @(negedge clk);
    compare();
    rst_n = r;
    adv   = a;
  endtask

  initial begin
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);                               // R1 reset held with advance
    cyc(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) cyc(1'b1, 1'b1);  // R2 steady stepping
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'($urandom_range(0, 1))); // R3 gaps
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0);   // R3 hold
    cyc(1'b0, 1'b1);                               // R9 reset beats advance
    cyc(1'b1, 1'b1);
    for (int i = 0; i < TERM + 20; i++) cyc(1'b1, 1'b1); // R7, R8 terminal then hold
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);                               // R9 reset at terminal
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1);   // R2 restart from 1
    cyc(1'b1, 1'b0);
    @(negedge clk);
    compare();
    chk("R9 restart value", int'(count), 6);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule